// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block sends one character at a time on an asynchronous serial line. A client offers a data byte with a valid/ready handshake. When the block is idle it takes the byte and sends a frame on `txd`: a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. All timing is counted in baud ticks. A separate generator supplies these as single-cycle pulses at sixteen times the bit rate. Each bit lasts sixteen ticks.

The shape of the frame comes from a byte of line control. Two bits give the word length. One bit gives the stop period. Three bits give the parity mode: none, odd, even, or forced to a fixed level. One bit forces the line to the spacing level. The framing fields are captured when a character is accepted, so software may rewrite the control byte while a character is in flight without changing that character. The break bit is not captured: it acts on the line at once.

Top module: `serial_tx_frame`

## Requirements
- R1: After a synchronous active-low reset, `txd` is 1 (idle marking level), `busy` is 0 and `data_ready` is 1.
- R2: Control bits 1:0 select the data bits per character: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8.
- R3: A frame starts with a logic-0 start bit. The data bits follow, least significant first. Each bit holds for 16 baud ticks. Data bits above the selected word length are not sent and do not affect parity.
- R4: Control bit 2 sets the stop period. When it is 0 there is one stop bit of 16 ticks. When it is 1 there are two stop bits (32 ticks), except for 5-bit characters, which get 24 ticks (1.5 bits). Stop bits are logic 1.
- R5: When control bit 3 (parity enable) is 0, no parity bit is sent, whatever bits 5 and 4 hold.
- R6: With bit 3 = 1 and bit 5 = 0, the parity bit follows the last data bit for 16 ticks. Bit 4 = 0 gives odd parity (data ones plus parity is odd). Bit 4 = 1 gives even parity.
- R7: With bit 3 = 1 and bit 5 = 1, the parity bit is forced to a fixed level: 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R8: While control bit 6 is 1, `txd` is 0 in the same cycle. When the bit returns to 0, the line goes back to its frame or idle level, and the frame timing is unaffected.
- R9: Word length, stop and parity settings, and the data byte, are captured in the accepting cycle. Later changes to `line_ctl` or `data_in` do not alter the character in flight.
- R10: `data_ready` equals not `busy`. A character is accepted on a clock edge where `data_valid` and `data_ready` are both 1. `busy` and the start bit appear in the next cycle. `data_valid` has no effect while busy.
- R11: `busy` falls on the baud tick that ends the last stop period. The line then rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_ctl | input | 8 | Line control: [1:0] word length, [2] stop, [3] parity enable, [4] even/level select, [5] forced parity, [6] break, [7] unused |
| tick16 | input | 1 | One-cycle baud pulse at 16x bit rate |
| data_in | input | 8 | Character to send |
| data_valid | input | 1 | Character offered |
| data_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial line output |
| busy | output | 1 | A frame is in progress |

## Verification
After an accepting edge, `busy`, `data_ready` and the start level are due in the very next cycle. Every later line change is due in the cycle after the baud tick that completes its 16-tick (or 8-tick half-stop) segment. The break override is due in the same cycle as the control change. A behavioural model in the bench keeps a queue of line levels and tick counts per frame. It advances on the same clock edges as the design, and its expected `txd`, `busy` and `data_ready` are compared at every falling edge. Inputs change 2 ns after a rising edge, so the model and the design see the same values.

// File: rtl/sertx_pkg.sv
// Shared definitions for the serial transmitter.
// Assumes a control byte whose field positions are fixed by the line-control
// layout below, and a character width of eight bits.
package sertx_pkg;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int MIN_BITS = 5;
    localparam int CFG_W    = 6;   // framing field bits [5:0] of the control byte

    localparam int WL_LSB    = 0;
    localparam int STOP_BIT  = 2;
    localparam int PEN_BIT   = 3;
    localparam int EVEN_BIT  = 4;
    localparam int FORCE_BIT = 5;
    localparam int BRK_BIT   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } tx_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] last_idx;
        logic             par_en;
        logic             par_bit;
        logic             two_stop;
        logic             half_stop;
    } frame_cfg_t;
endpackage

// File: rtl/sertx_ctl_decode.sv
// Combinational decode of the framing field and the offered data byte.
// Produces the index of the last data bit, the parity bit value and the stop
// shape, plus the data byte with bits above the word length cleared.
// Assumes the caller registers the outputs when a character is accepted.
module sertx_ctl_decode
    import sertx_pkg::*;
(
    input  logic [CFG_W-1:0]  ctl,
    input  logic [DATA_W-1:0] data,
    output frame_cfg_t        cfg,
    output logic [DATA_W-1:0] data_m
);
    logic [1:0]       wl;
    logic [IDX_W-1:0] last;
    logic             xor_all;

    assign wl   = ctl[WL_LSB +: 2];
    assign last = IDX_W'(MIN_BITS - 1) + IDX_W'(wl);

    // Mask each data bit that lies beyond the selected word length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign data_m[i] = data[i] & (IDX_W'(i) <= last);
    end

    assign xor_all = ^data_m;

    // Assemble the frame settings from the control field.
    always_comb begin
        cfg.last_idx  = last;
        cfg.par_en    = ctl[PEN_BIT];
        if (ctl[FORCE_BIT])
            cfg.par_bit = ~ctl[EVEN_BIT];
        else if (ctl[EVEN_BIT])
            cfg.par_bit = xor_all;
        else
            cfg.par_bit = ~xor_all;
        cfg.two_stop  = ctl[STOP_BIT];
        cfg.half_stop = ctl[STOP_BIT] && (wl == 2'd0);
    end
endmodule

// File: rtl/sertx_seg_timer.sv
// Counts baud ticks within one line segment (one bit or half a bit).
// seg_done pulses on the tick that completes the segment. The count restarts
// at zero whenever the block is idle or a segment completes.
// Assumes tick is a single-cycle pulse.
module sertx_seg_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic half,
    output logic seg_done
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);

    logic [CNT_W-1:0] cnt;

    assign seg_done = run && tick && (cnt == (half ? HALF_LAST : FULL_LAST));

    // Advance the tick count inside the current segment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || seg_done)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sertx_shifter.sv
// Holds the character in flight and presents its next data bit.
// Loads the masked byte on accept and shifts right once per finished data
// bit. It flags when the current bit is the last one of the word.
// Assumes shift is asserted only during the data phase.
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              cur_bit,
    output logic              at_last
);
    logic [DATA_W-1:0] sh;
    logic [IDX_W-1:0]  idx;

    assign cur_bit = sh[0];
    assign at_last = (idx == last_idx);

    // Load the character or move on to its next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= load_data;
            idx <= '0;
        end else if (shift) begin
            sh  <= {1'b0, sh[DATA_W-1:1]};
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_fsm.sv
// Frame sequencer: idle, start, data, optional parity, one or two stop
// segments. Moves on only when the segment timer reports completion.
// Assumes the captured settings stay stable for the whole frame.
module sertx_fsm
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      seg_done,
    input  logic      at_last,
    input  logic      par_en,
    input  logic      two_stop,
    output tx_state_t state,
    output logic      shift
);
    tx_state_t nxt;

    assign shift = seg_done && (state == ST_DATA) && !at_last;

    // Choose the next frame phase.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start) nxt = ST_START;
            ST_START: if (seg_done) nxt = ST_DATA;
            ST_DATA:  if (seg_done && at_last) nxt = par_en ? ST_PAR : ST_STOP;
            ST_PAR:   if (seg_done) nxt = ST_STOP;
            ST_STOP:  if (seg_done) nxt = two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2: if (seg_done) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Register the frame phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/serial_tx_frame.sv
// Asynchronous serial transmitter with programmable framing.
// Accepts a character when idle, captures its framing settings, and drives
// txd from the frame phase. The break bit overrides the line at once.
// Assumes tick16 is a one-cycle pulse at OVERSAMPLE times the bit rate.
module serial_tx_frame
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        line_ctl,
    input  logic              tick16,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_valid,
    output logic              data_ready,
    output logic              txd,
    output logic              busy
);
    frame_cfg_t        cfg_d, cfg_q;
    logic [DATA_W-1:0] data_m;
    tx_state_t         state;
    logic              accept, seg_done, shift, shift_any;
    logic              cur_bit, at_last, frame_bit, half_seg;
    logic              ctl_unused;

    assign ctl_unused = line_ctl[7];

    assign data_ready = (state == ST_IDLE);
    assign busy       = !data_ready;
    assign accept     = data_valid && data_ready;
    assign half_seg   = (state == ST_STOP2) && cfg_q.half_stop;
    assign shift_any  = shift;

    sertx_ctl_decode u_dec (
        .ctl    (line_ctl[CFG_W-1:0]),
        .data   (data_in),
        .cfg    (cfg_d),
        .data_m (data_m)
    );

    // Capture the framing settings of the accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (accept)
            cfg_q <= cfg_d;
    end

    sertx_seg_timer #(.OVERSAMPLE(OVERSAMPLE)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .tick     (tick16),
        .half     (half_seg),
        .seg_done (seg_done)
    );

    sertx_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (data_m),
        .shift     (shift_any),
        .last_idx  (cfg_q.last_idx),
        .cur_bit   (cur_bit),
        .at_last   (at_last)
    );

    sertx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .seg_done (seg_done),
        .at_last  (at_last),
        .par_en   (cfg_q.par_en),
        .two_stop (cfg_q.two_stop),
        .state    (state),
        .shift    (shift)
    );

    // Select the line level for the current frame phase.
    always_comb begin
        case (state)
            ST_START: frame_bit = 1'b0;
            ST_DATA:  frame_bit = cur_bit;
            ST_PAR:   frame_bit = cfg_q.par_bit;
            default:  frame_bit = 1'b1;
        endcase
    end

    assign txd = line_ctl[BRK_BIT] ? 1'b0 : frame_bit;
endmodule

// File: rtl/sertx_chk.sv
// Protocol checker for serial_tx_frame, attached by bind. Watches ports only.
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] line_ctl,
    input logic       tick16,
    input logic       data_valid,
    input logic       data_ready,
    input logic       txd,
    input logic       busy
);
    a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl[6] |-> !txd);

    a_r10_ready_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == !busy);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_ready) |=> busy);

    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !line_ctl[6]) |-> !txd);

    a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !line_ctl[6]) |-> txd);

    a_r11_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick16) |=> busy);
endmodule

bind serial_tx_frame sertx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_ctl   (line_ctl),
    .tick16     (tick16),
    .data_valid (data_valid),
    .data_ready (data_ready),
    .txd        (txd),
    .busy       (busy)
);

// File: tb/serial_tx_frame_tb_top.sv
module serial_tx_frame_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_ctl = 8'h00;
    logic [7:0] data_in = 8'h00;
    logic       data_valid = 1'b0;
    logic       tick16 = 1'b0;
    logic       data_ready, txd, busy;

    always #4 clk = ~clk;   // 125 MHz

    serial_tx_frame dut_i (
        .clk(clk), .rst_n(rst_n), .line_ctl(line_ctl), .tick16(tick16),
        .data_in(data_in), .data_valid(data_valid), .data_ready(data_ready),
        .txd(txd), .busy(busy)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R3";
    int    lvl_q[$];
    int    len_q[$];
    int    rem = 0;
    bit    m_busy = 0;
    int    m_frames = 0, dut_frames = 0;
    bit    busy_prev = 0;
    int    tdiv = 0;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Queue the line levels and tick lengths of one frame.
    function automatic void build(logic [7:0] c, logic [7:0] d);
        int nb = 5 + int'(c[1:0]);
        int ones = 0;
        int par;
        lvl_q.push_back(0); len_q.push_back(16);
        for (int i = 0; i < nb; i++) begin
            lvl_q.push_back(int'(d[i])); len_q.push_back(16);
            ones += int'(d[i]);
        end
        if (c[3]) begin
            if (c[5]) par = c[4] ? 0 : 1;
            else if (c[4]) par = ones % 2;
            else par = (ones % 2 == 0) ? 1 : 0;
            lvl_q.push_back(par); len_q.push_back(16);
        end
        lvl_q.push_back(1); len_q.push_back(16);
        if (c[2]) begin
            lvl_q.push_back(1); len_q.push_back(nb == 5 ? 8 : 16);
        end
    endfunction

    // Reference model: advances on the same rising edges as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            lvl_q.delete(); len_q.delete(); m_busy = 0;
        end else if (m_busy) begin
            if (tick16) begin
                rem--;
                if (rem == 0) begin
                    void'(lvl_q.pop_front());
                    void'(len_q.pop_front());
                    if (lvl_q.size() == 0) m_busy = 0;
                    else rem = len_q[0];
                end
            end
        end else if (data_valid) begin
            build(line_ctl, data_in);
            m_busy = 1; rem = 16; m_frames++;
        end
    end

    // Baud pulse every third cycle, driven off the edge.
    always @(posedge clk) begin
        #2;
        tdiv = (tdiv + 1) % 3;
        tick16 = (tdiv == 0);
    end

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_txd;
            exp_txd = line_ctl[6] ? 0 : (m_busy ? lvl_q[0] : 1);
            check(cur_req, "txd", int'(txd), exp_txd);
            check("R11", "busy", int'(busy), int'(m_busy));
            check("R10", "data_ready", int'(data_ready), int'(!m_busy));
            if (busy && !busy_prev) dut_frames++;
            busy_prev = busy;
        end
    end

    task automatic wait_idle();
        while (m_busy) begin @(posedge clk); #1; end
        #1;
    endtask

    task automatic send(logic [7:0] c, logic [7:0] d);
        wait_idle();
        @(posedge clk); #2;
        line_ctl = c; data_in = d; data_valid = 1'b1;
        @(posedge clk); #2;
        data_valid = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", "reset txd", int'(txd), 1);
        check("R1", "reset busy", int'(busy), 0);
        check("R1", "reset ready", int'(data_ready), 1);
        @(posedge clk); #2; rst_n = 1'b1;

        cur_req = "R2";
        for (int w = 0; w < 4; w++) send(8'(w), 8'hB6);

        cur_req = "R3";
        send(8'h03, 8'h01);
        send(8'h03, 8'h80);
        send(8'h00, 8'hE0);

        cur_req = "R4";
        send(8'h04, 8'h15);
        send(8'h07, 8'h3C);
        send(8'h05, 8'h2A);

        cur_req = "R5";
        send(8'h33, 8'hF1);

        cur_req = "R6";
        send(8'h0B, 8'h00); send(8'h0B, 8'h01); send(8'h0B, 8'h7F);
        send(8'h1B, 8'h00); send(8'h1B, 8'h01); send(8'h1A, 8'h7F);

        cur_req = "R7";
        send(8'h2B, 8'h01); send(8'h3B, 8'h00); send(8'h28, 8'h1F);

        cur_req = "R8";
        wait_idle();
        @(posedge clk); #2; line_ctl = 8'h40;
        @(negedge clk); check("R8", "break idle txd", int'(txd), 0);
        repeat (20) @(posedge clk); #2; line_ctl = 8'h00;
        send(8'h03, 8'h55);
        repeat (50) @(posedge clk); #2; line_ctl = 8'h43;
        @(negedge clk); check("R8", "break mid txd", int'(txd), 0);
        repeat (40) @(posedge clk); #2; line_ctl = 8'h03;

        cur_req = "R9";
        send(8'h03, 8'hC3);
        repeat (30) @(posedge clk); #2; line_ctl = 8'h2C; data_in = 8'h00;
        wait_idle();

        cur_req = "R10";
        @(posedge clk); #2;
        line_ctl = 8'h0F; data_in = 8'h96; data_valid = 1'b1;
        repeat (2000) @(posedge clk);
        #2; data_valid = 1'b0;
        wait_idle();
        @(negedge clk);
        check("R10", "frame count", dut_frames, m_frames);

        cur_req = "R11";
        send(8'h00, 8'h0A);
        wait_idle();
        @(negedge clk);
        check("R11", "end txd", int'(txd), 1);
        check("R11", "end busy", int'(busy), 0);

        summary();
        $finish;
    end
endmodule